// File: doc/BRIEF.md
# Keyed Configuration Index/Data Port

This block is the host-facing front end of a legacy configuration space. It sits on a byte-wide bus and answers two neighbouring addresses. The lower address is the index port and the next address up is the data port. Before any configuration register can be touched, the host has to open the space by writing a two-byte entry key to the index port. A single exit byte written to the same port closes it again. While the space is closed, reads of either port return 0xFF and writes have no effect.

Once the space is open, the host writes a register number to the index port and then reads or writes that register through the data port. Register numbers below 0x30 form a global area shared by every function on the chip. It holds the device-select register at 0x07 and the read-only identification bytes at 0x20 and 0x21. Register numbers from 0x30 upward form a banked area. The device-select register chooses which logical device's bank they reach. Accesses to the banked area leave the block as single-cycle strobes that carry the selected device number, the register number and the write data. The selected device returns read data on a shared return bus.

The unlock logic is a three-state machine. From **LOCKED**, an index write of 0x87 goes to **KEY_HALF** (transition *first_key*). From **KEY_HALF**, a second index write of 0x87 goes to **OPEN** (transition *second_key*). Any other index write in **KEY_HALF** returns to **LOCKED** (transition *key_broken*). In **OPEN**, an index write of 0xAA returns to **LOCKED** (transition *exit_key*). Every other index write in **OPEN** stays in **OPEN** (transition *index_load*). The port pair sits at 0x2E/0x2F, or at 0x4E/0x4F when the strap input `base_sel` is high.

Top module: `cfg_key_port`

## Requirements
- R1: After reset the space is closed, the index register is 0x00 and the device-select register (0x07) is 0x00.
- R2: Two index-port writes of 0x87, with no other index write between them, open the space; after only one of them the space is still closed.
- R3: An index-port write of any other value after the first 0x87 of the entry key breaks the match; the space then needs two further 0x87 writes to open.
- R4: While the space is closed, every read of the index or data port returns 0xFF; data-port writes produce no bank strobe and change no register.
- R5: An index-port write of 0xAA while open closes the space and does not load 0xAA into the index register; the previous index value is kept.
- R6: With `base_sel` low the ports are 0x2E (index) and 0x2F (data); with it high they are 0x4E and 0x4F; any other address reads 0xFF and writes to it have no effect.
- R7: With index 0x07, data-port writes load the device-select register and data-port reads return it.
- R8: Index 0x20 reads the upper byte of the chip ID (default 0xA2) and index 0x21 reads the lower byte (default 0x36); writes to them have no effect.
- R9: A data-port write while open with index >= 0x30 raises `bk_wr` for that cycle, with `bk_dev` = device select, `bk_reg` = index and `bk_wdata` = written byte; an index below 0x30 raises no strobe.
- R10: A data-port read while open with index >= 0x30 raises `bk_rd` for that cycle and returns `bk_rdata` on `bus_rdata`.
- R11: When a read and a write reach the port in the same cycle, the read returns the state from before that cycle's write.
- R12: Global registers other than 0x07, 0x20 and 0x21 read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_sel | input | 1 | Port pair strap: 0 selects 0x2E/0x2F, 1 selects 0x4E/0x4F |
| bus_addr | input | 16 | Bus address |
| bus_wr | input | 1 | Write enable for this cycle |
| bus_rd | input | 1 | Read enable for this cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the same cycle as `bus_rd` |
| bk_wr | output | 1 | Banked register write strobe |
| bk_rd | output | 1 | Banked register read strobe |
| bk_dev | output | 8 | Selected logical device number |
| bk_reg | output | 8 | Banked register number |
| bk_wdata | output | 8 | Banked write data |
| bk_rdata | input | 8 | Read data returned by the selected device |

## Verification
A read and a write can reach the port in the same cycle. Reads are combinational and writes take effect at the clock edge, so the read must return the pre-write state. Two cases provoke this. In the first, the bench writes and reads the device-select register through the data port in one cycle. The read must show the old value, and a later read the new one. In the second, the bench writes the exit key to the index port while reading that port in the same cycle. That read must still return the index value, and only the next read returns 0xFF.

// File: rtl/cfg_key_port_pkg.sv
package cfg_key_port_pkg;

    typedef enum logic [1:0] {
        ST_LOCKED   = 2'd0,
        ST_KEY_HALF = 2'd1,
        ST_OPEN     = 2'd2
    } key_state_e;

    localparam logic [7:0] DEF_KEY_ENTER  = 8'h87;
    localparam logic [7:0] DEF_KEY_EXIT   = 8'hAA;
    localparam logic [7:0] DEF_DEVSEL_REG = 8'h07;
    localparam logic [7:0] DEF_ID_HI_REG  = 8'h20;
    localparam logic [7:0] DEF_ID_LO_REG  = 8'h21;
    localparam logic [7:0] DEF_BANK_START = 8'h30;
    localparam logic [7:0] IDLE_READ      = 8'hFF;

endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] BASE_LO  = 16'h002E,
    parameter logic [ADDR_W-1:0] BASE_HI  = 16'h004E
) (
    input  logic              base_sel,
    input  logic [ADDR_W-1:0] addr,
    output logic              idx_hit,
    output logic              dat_hit
);
    logic [ADDR_W-1:0] base;

    always_comb begin
        base    = base_sel ? BASE_HI : BASE_LO;
        idx_hit = (addr == base);
        dat_hit = (addr == base + ADDR_W'(1));
    end
endmodule

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
    import cfg_key_port_pkg::*;
#(
    parameter logic [7:0] KEY_ENTER = DEF_KEY_ENTER,
    parameter logic [7:0] KEY_EXIT  = DEF_KEY_EXIT
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       open
);
    key_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: begin
                if (idx_wr && wdata == KEY_ENTER) state_d = ST_KEY_HALF;   // first_key
            end
            ST_KEY_HALF: begin
                if (idx_wr) begin
                    if (wdata == KEY_ENTER) state_d = ST_OPEN;             // second_key
                    else                    state_d = ST_LOCKED;           // key_broken
                end
            end
            ST_OPEN: begin
                if (idx_wr && wdata == KEY_EXIT) state_d = ST_LOCKED;      // exit_key
            end
            default: state_d = ST_LOCKED;
        endcase
    end

    always_comb begin
        open = 1'b0;
        unique case (state_q)
            ST_OPEN:     open = 1'b1;
            ST_LOCKED,
            ST_KEY_HALF: open = 1'b0;
            default:     open = 1'b0;
        endcase
    end

    // R2
    second_key_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_KEY_HALF && idx_wr && wdata == KEY_ENTER) |=> open);

    // R3
    broken_key_relocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_KEY_HALF && idx_wr && wdata != KEY_ENTER) |=> (state_q == ST_LOCKED));

    // R5
    exit_key_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open && idx_wr && wdata == KEY_EXIT) |=> !open);
endmodule

// File: rtl/cfg_reg_space.sv
module cfg_reg_space
    import cfg_key_port_pkg::*;
#(
    parameter logic [15:0] CHIP_ID    = 16'hA236,
    parameter logic [7:0]  KEY_EXIT   = DEF_KEY_EXIT,
    parameter logic [7:0]  DEVSEL_REG = DEF_DEVSEL_REG,
    parameter logic [7:0]  ID_HI_REG  = DEF_ID_HI_REG,
    parameter logic [7:0]  ID_LO_REG  = DEF_ID_LO_REG,
    parameter logic [7:0]  BANK_START = DEF_BANK_START
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       open,
    input  logic       idx_wr,
    input  logic       idx_rd,
    input  logic       dat_wr,
    input  logic       dat_rd,
    input  logic [7:0] wdata,
    input  logic [7:0] bk_rdata,
    output logic [7:0] rdata,
    output logic       bk_wr,
    output logic       bk_rd,
    output logic [7:0] bk_dev,
    output logic [7:0] bk_reg
);
    logic [7:0] index_q;
    logic [7:0] devsel_q;
    logic [7:0] global_val;
    logic       in_bank;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q  <= 8'h00;
            devsel_q <= 8'h00;
        end else begin
            if (open && idx_wr && wdata != KEY_EXIT) index_q <= wdata;
            if (open && dat_wr && index_q == DEVSEL_REG) devsel_q <= wdata;
        end
    end

    always_comb begin
        in_bank = (index_q >= BANK_START);
        if (index_q == DEVSEL_REG)     global_val = devsel_q;
        else if (index_q == ID_HI_REG) global_val = CHIP_ID[15:8];
        else if (index_q == ID_LO_REG) global_val = CHIP_ID[7:0];
        else                           global_val = 8'h00;
    end

    always_comb begin
        bk_wr  = open && dat_wr && in_bank;
        bk_rd  = open && dat_rd && in_bank;
        bk_dev = devsel_q;
        bk_reg = index_q;
        if (open && idx_rd)      rdata = index_q;
        else if (open && dat_rd) rdata = in_bank ? bk_rdata : global_val;
        else                     rdata = IDLE_READ;
    end

    // R4
    closed_devsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !open |=> $stable(devsel_q));

    // R7
    devsel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open && dat_wr && index_q == DEVSEL_REG) |=> (devsel_q == $past(wdata)));

    // R5
    exit_keeps_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_wr && wdata == KEY_EXIT) |=> $stable(index_q));
endmodule

// File: rtl/cfg_key_port.sv
module cfg_key_port
    import cfg_key_port_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] BASE_LO    = 16'h002E,
    parameter logic [ADDR_W-1:0] BASE_HI    = 16'h004E,
    parameter logic [15:0]       CHIP_ID    = 16'hA236,
    parameter logic [7:0]        KEY_ENTER  = DEF_KEY_ENTER,
    parameter logic [7:0]        KEY_EXIT   = DEF_KEY_EXIT,
    parameter logic [7:0]        BANK_START = DEF_BANK_START
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              bk_wr,
    output logic              bk_rd,
    output logic [7:0]        bk_dev,
    output logic [7:0]        bk_reg,
    output logic [7:0]        bk_wdata,
    input  logic [7:0]        bk_rdata
);
    logic idx_hit, dat_hit, open;
    logic idx_wr, idx_rd, dat_wr, dat_rd;

    cfg_port_decode #(.ADDR_W(ADDR_W), .BASE_LO(BASE_LO), .BASE_HI(BASE_HI)) u_dec (
        .base_sel (base_sel),
        .addr     (bus_addr),
        .idx_hit  (idx_hit),
        .dat_hit  (dat_hit)
    );

    always_comb begin
        idx_wr   = bus_wr && idx_hit;
        idx_rd   = bus_rd && idx_hit;
        dat_wr   = bus_wr && dat_hit;
        dat_rd   = bus_rd && dat_hit;
        bk_wdata = bus_wdata;
    end

    cfg_key_fsm #(.KEY_ENTER(KEY_ENTER), .KEY_EXIT(KEY_EXIT)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx_wr (idx_wr),
        .wdata  (bus_wdata),
        .open   (open)
    );

    cfg_reg_space #(.CHIP_ID(CHIP_ID), .KEY_EXIT(KEY_EXIT), .BANK_START(BANK_START)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .open     (open),
        .idx_wr   (idx_wr),
        .idx_rd   (idx_rd),
        .dat_wr   (dat_wr),
        .dat_rd   (dat_rd),
        .wdata    (bus_wdata),
        .bk_rdata (bk_rdata),
        .rdata    (bus_rdata),
        .bk_wr    (bk_wr),
        .bk_rd    (bk_rd),
        .bk_dev   (bk_dev),
        .bk_reg   (bk_reg)
    );

    // R4
    closed_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!open && bus_wr && !idx_hit) |=> !(bk_wr || bk_rd) || open);
endmodule

// File: tb/tb_cfg_key_port.sv
`timescale 1ns/1ps
module tb_cfg_key_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_sel = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        bk_wr, bk_rd;
    logic [7:0]  bk_dev, bk_reg, bk_wdata, bk_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [7:0] c_rd, c_dev, c_reg, c_wd;
    logic       c_bwr, c_brd;

    always #4 clk = ~clk;

    function automatic logic [7:0] bmodel(input logic [7:0] d, input logic [7:0] r);
        return {d[3:0], r[3:0]} ^ 8'h5A;
    endfunction

    assign bk_rdata = bmodel(bk_dev, bk_reg);

    cfg_key_port dut (
        .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bk_wr(bk_wr), .bk_rd(bk_rd), .bk_dev(bk_dev), .bk_reg(bk_reg),
        .bk_wdata(bk_wdata), .bk_rdata(bk_rdata)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic drive(input logic w, input logic r, input logic [15:0] a, input logic [7:0] d);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
        #2;
        c_rd = bus_rdata; c_bwr = bk_wr; c_brd = bk_rd;
        c_dev = bk_dev; c_reg = bk_reg; c_wd = bk_wdata;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 16'h0000; bus_wdata = 8'h00;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d); drive(1'b1, 1'b0, a, d); endtask
    task automatic rd(input logic [15:0] a);                      drive(1'b0, 1'b1, a, 8'h00); endtask
    task automatic unlock(); wr(16'h2E, 8'h87); wr(16'h2E, 8'h87); endtask
    task automatic lock();   wr(16'h2E, 8'hAA); endtask

    task automatic t_reset();
        rd(16'h2E); check("R1 closed index read", c_rd, 8'hFF);
        rd(16'h2F); check("R1 closed data read", c_rd, 8'hFF);
        unlock();
        rd(16'h2E); check("R1 index reset value", c_rd, 8'h00);
        wr(16'h2E, 8'h07); rd(16'h2F); check("R1 devsel reset value", c_rd, 8'h00);
        lock();
    endtask

    task automatic t_unlock();
        wr(16'h2E, 8'h87);
        rd(16'h2F); check("R2 one key still closed", c_rd, 8'hFF);
        wr(16'h2E, 8'h87);
        wr(16'h2E, 8'h21); rd(16'h2F); check("R2 open after two keys", c_rd, 8'h36);
        lock();
    endtask

    task automatic t_restart();
        wr(16'h2E, 8'h87); wr(16'h2E, 8'h55); wr(16'h2E, 8'h87);
        rd(16'h2E); check("R3 broken key stays closed", c_rd, 8'hFF);
        wr(16'h2E, 8'h87);
        rd(16'h2E); check("R3 opens after fresh pair", c_rd, 8'h21);
        lock();
    endtask

    task automatic t_closed_ignore();
        unlock(); wr(16'h2E, 8'h07); wr(16'h2F, 8'h03); wr(16'h2E, 8'h30); lock();
        wr(16'h2F, 8'h99); check("R4 no bank strobe while closed", {7'd0, c_bwr}, 8'h00);
        unlock(); wr(16'h2E, 8'h07); lock();
        wr(16'h2F, 8'h44);
        unlock(); rd(16'h2F); check("R4 devsel unchanged by closed write", c_rd, 8'h03);
        lock();
    endtask

    task automatic t_exit();
        unlock(); wr(16'h2E, 8'h21); wr(16'h2E, 8'hAA);
        rd(16'h2E); check("R5 exit closes", c_rd, 8'hFF);
        unlock();
        rd(16'h2E); check("R5 exit byte not stored", c_rd, 8'h21);
        lock();
    endtask

    task automatic t_base();
        unlock();
        rd(16'h4E); check("R6 alternate port inactive", c_rd, 8'hFF);
        wr(16'h4F, 8'h77);
        rd(16'h2F); check("R6 foreign write ignored", c_rd, 8'h36);
        base_sel = 1'b1;
        rd(16'h4E); check("R6 alternate index port", c_rd, 8'h21);
        rd(16'h2E); check("R6 default port off", c_rd, 8'hFF);
        wr(16'h4E, 8'hAA);
        rd(16'h4E); check("R6 exit via alternate", c_rd, 8'hFF);
        base_sel = 1'b0;
    endtask

    task automatic t_devsel_chipid();
        unlock();
        wr(16'h2E, 8'h07); wr(16'h2F, 8'h0B);
        rd(16'h2F); check("R7 devsel readback", c_rd, 8'h0B);
        wr(16'h2E, 8'h20); rd(16'h2F); check("R8 chip id high", c_rd, 8'hA2);
        wr(16'h2F, 8'h00); rd(16'h2F); check("R8 chip id read-only", c_rd, 8'hA2);
        wr(16'h2E, 8'h21); rd(16'h2F); check("R8 chip id low", c_rd, 8'h36);
    endtask

    task automatic t_bank();
        wr(16'h2E, 8'h31); wr(16'h2F, 8'h5C);
        check("R9 bank write strobe", {7'd0, c_bwr}, 8'h01);
        check("R9 bank device", c_dev, 8'h0B);
        check("R9 bank register", c_reg, 8'h31);
        check("R9 bank data", c_wd, 8'h5C);
        wr(16'h2E, 8'h25); wr(16'h2F, 8'h66);
        check("R9 no strobe below bank", {7'd0, c_bwr}, 8'h00);
        rd(16'h2F); check("R12 unused global reads zero", c_rd, 8'h00);
        wr(16'h2E, 8'h3F); rd(16'h2F);
        check("R10 bank read strobe", {7'd0, c_brd}, 8'h01);
        check("R10 bank read data", c_rd, bmodel(8'h0B, 8'h3F));
    endtask

    task automatic t_same_cycle();
        wr(16'h2E, 8'h07);
        drive(1'b1, 1'b1, 16'h2F, 8'h04);
        check("R11 read sees old devsel", c_rd, 8'h0B);
        rd(16'h2F); check("R11 write landed", c_rd, 8'h04);
        drive(1'b1, 1'b1, 16'h2E, 8'hAA);
        check("R11 read during exit", c_rd, 8'h07);
        rd(16'h2E); check("R11 closed after exit", c_rd, 8'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unlock();
        t_restart();
        t_closed_ignore();
        t_exit();
        t_base();
        t_devsel_chipid();
        t_bank();
        t_same_cycle();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule